// File: doc/BRIEF.md
# Garage Door Motor Controller

A clocked controller that turns two operator commands, open and close, plus a numeric door position into two motor drive lines, one for raising the door and one for lowering it. Position 0 is fully closed and position 100 is fully open; any reading above 100 is taken as fully open. The controller holds one of three motion states (stopped, raising, lowering) and drives the motor from that state alone, so both drive lines come straight from flops.

A single command pulse is enough to start travel: once moving, the door keeps going until the position reaches the limit in the direction of travel, or until a conflicting or reversing command arrives. A reversal never switches the motor directly from one direction to the other; the controller spends one clock cycle stopped first. Both commands at once stop the motor.

Top module: `door_motor_ctrl`

## Requirements
- R1: While rst_ni is low both up_o and down_o are 0, and after reset the controller is stopped.
- R2: From stopped, open_i=1 with close_i=0 and pos_i below 100 makes up_o=1 from the next clock edge.
- R3: While raising, up_o stays 1 with no command held, and the first edge at which pos_i is 100 or more returns the controller to stopped.
- R4: From stopped, close_i=1 with open_i=0 and pos_i above 0 makes down_o=1 from the next clock edge.
- R5: While lowering, down_o stays 1 with no command held, and the first edge at which pos_i is 0 returns the controller to stopped.
- R6: open_i while pos_i is 100 or more, and close_i while pos_i is 0, leave the controller stopped.
- R7: open_i and close_i high together at an edge leave both outputs 0 after that edge, from any state.
- R8: A command opposite to the current travel stops the motor at the next edge; the reverse direction is driven one edge later if the command is still held.
- R9: up_o and down_o are never 1 together.
- R10: pos_i values 101 to 127 behave as fully open, both for starting and for ending upward travel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| open_i | input | 1 | Open command |
| close_i | input | 1 | Close command |
| pos_i | input | 7 | Door position, 0 closed, 100 or more open |
| up_o | output | 1 | Raise motor drive |
| down_o | output | 1 | Lower motor drive |

## Verification
The bench walks a cycle-by-cycle table through full raise and lower runs, the exact limit values 0, 99, 100 and out-of-range readings above 100, where an off-by-one limit compare would either stall at 99 or overrun past 100. It drives reversals in both directions and checks for the single stopped cycle, which a design that flips direction in one step would skip, and it drives both commands together while stopped and while moving, where a priority-based design would move one way. A reset asserted mid-travel checks that the drives drop without waiting for a clock.

// File: rtl/door_ctrl_pkg.sv
package door_ctrl_pkg;

  typedef enum logic [1:0] {
    MOT_STOP = 2'b00,
    MOT_UP   = 2'b01,
    MOT_DOWN = 2'b10
  } motion_e;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_OPEN     = 2'b01,
    CMD_CLOSE    = 2'b10,
    CMD_CONFLICT = 2'b11
  } cmd_e;

endpackage

// File: rtl/door_cmd_decode.sv
module door_cmd_decode
  import door_ctrl_pkg::*;
(
  input  logic open_i,
  input  logic close_i,
  output cmd_e cmd_o
);

  always_comb begin
    unique case ({close_i, open_i})
      2'b01:   cmd_o = CMD_OPEN;
      2'b10:   cmd_o = CMD_CLOSE;
      2'b11:   cmd_o = CMD_CONFLICT;
      default: cmd_o = CMD_NONE;
    endcase
  end

endmodule

// File: rtl/door_limit_check.sv
module door_limit_check #(
  parameter int unsigned POS_W    = 7,
  parameter int unsigned POS_OPEN = 100
) (
  input  logic [POS_W-1:0] pos_i,
  output logic             at_open_o,
  output logic             at_closed_o
);

  localparam logic [POS_W-1:0] OpenLim = POS_W'(POS_OPEN);

  // readings beyond the open limit count as fully open
  assign at_open_o   = (pos_i >= OpenLim);
  assign at_closed_o = (pos_i == '0);

endmodule

// File: rtl/door_motion_fsm.sv
module door_motion_fsm
  import door_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic at_open_i,
  input  logic at_closed_i,
  output logic up_o,
  output logic down_o
);

  motion_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MOT_STOP: begin
        if (cmd_i == CMD_OPEN && !at_open_i)         state_d = MOT_UP;
        else if (cmd_i == CMD_CLOSE && !at_closed_i) state_d = MOT_DOWN;
      end
      MOT_UP: begin
        // reversal and conflict both go through stop
        if (cmd_i == CMD_CLOSE || cmd_i == CMD_CONFLICT || at_open_i)
          state_d = MOT_STOP;
      end
      MOT_DOWN: begin
        if (cmd_i == CMD_OPEN || cmd_i == CMD_CONFLICT || at_closed_i)
          state_d = MOT_STOP;
      end
      default: state_d = MOT_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MOT_STOP;
    else         state_q <= state_d;
  end

  assign up_o   = (state_q == MOT_UP);
  assign down_o = (state_q == MOT_DOWN);

  a_r9_drive_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && down_o));

  a_r7_conflict_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CONFLICT) |=> (!up_o && !down_o));

  a_r3_open_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_open_i |=> !up_o);

  a_r5_closed_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_closed_i |=> !down_o);

  a_r8_no_direct_flip_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |=> !down_o);

  a_r8_no_direct_flip_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_o |=> !up_o);

  a_r2_start_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_o && !down_o && cmd_i == CMD_OPEN && !at_open_i) |=> up_o);

  a_r4_start_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_o && !down_o && cmd_i == CMD_CLOSE && !at_closed_i) |=> down_o);

endmodule

// File: rtl/door_motor_ctrl.sv
module door_motor_ctrl #(
  parameter int unsigned POS_W    = 7,
  parameter int unsigned POS_OPEN = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             up_o,
  output logic             down_o
);
  import door_ctrl_pkg::*;

  localparam int unsigned PosSpan = 1 << POS_W;

  cmd_e cmd;
  logic at_open, at_closed;

  door_cmd_decode u_cmd (
    .open_i  (open_i),
    .close_i (close_i),
    .cmd_o   (cmd)
  );

  door_limit_check #(
    .POS_W    (POS_W),
    .POS_OPEN (POS_OPEN)
  ) u_limit (
    .pos_i       (pos_i),
    .at_open_o   (at_open),
    .at_closed_o (at_closed)
  );

  door_motion_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .at_open_i   (at_open),
    .at_closed_i (at_closed),
    .up_o        (up_o),
    .down_o      (down_o)
  );

  initial begin
    a_open_limit_fits: assert (POS_OPEN > 0 && POS_OPEN < PosSpan);
  end

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!up_o && !down_o));

endmodule

// File: tb/door_motor_ctrl_tb.sv
module door_motor_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       open_c, close_c;
  logic [6:0] pos;
  logic       up, down;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  door_motor_ctrl u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .open_i  (open_c),
    .close_i (close_c),
    .pos_i   (pos),
    .up_o    (up),
    .down_o  (down)
  );

  // {open, close, pos, exp_up, exp_down, req}; expectation holds after the edge
  localparam int NVEC = 23;
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 7'd10,  1'b1, 1'b0, 4'd2},   // R2 start raising
    {1'b0, 1'b0, 7'd50,  1'b1, 1'b0, 4'd3},   // R3 coast
    {1'b0, 1'b0, 7'd99,  1'b1, 1'b0, 4'd3},   // R3 one short of limit
    {1'b0, 1'b0, 7'd100, 1'b0, 1'b0, 4'd3},   // R3 limit reached
    {1'b1, 1'b0, 7'd100, 1'b0, 1'b0, 4'd6},   // R6 open at limit
    {1'b1, 1'b0, 7'd120, 1'b0, 1'b0, 4'd10},  // R10 beyond limit
    {1'b0, 1'b1, 7'd120, 1'b0, 1'b1, 4'd4},   // R4 start lowering
    {1'b0, 1'b0, 7'd60,  1'b0, 1'b1, 4'd5},   // R5 coast
    {1'b0, 1'b0, 7'd1,   1'b0, 1'b1, 4'd5},   // R5 one above closed
    {1'b0, 1'b0, 7'd0,   1'b0, 1'b0, 4'd5},   // R5 closed
    {1'b0, 1'b1, 7'd0,   1'b0, 1'b0, 4'd6},   // R6 close at closed
    {1'b1, 1'b1, 7'd40,  1'b0, 1'b0, 4'd7},   // R7 conflict while stopped
    {1'b1, 1'b0, 7'd40,  1'b1, 1'b0, 4'd2},
    {1'b1, 1'b1, 7'd41,  1'b0, 1'b0, 4'd7},   // R7 conflict while raising
    {1'b0, 1'b1, 7'd41,  1'b0, 1'b1, 4'd4},
    {1'b1, 1'b0, 7'd40,  1'b0, 1'b0, 4'd8},   // R8 reverse: stop first
    {1'b1, 1'b0, 7'd40,  1'b1, 1'b0, 4'd8},   // R8 then raise
    {1'b0, 1'b1, 7'd45,  1'b0, 1'b0, 4'd8},   // R8 reverse: stop first
    {1'b0, 1'b1, 7'd45,  1'b0, 1'b1, 4'd8},   // R8 then lower
    {1'b0, 1'b0, 7'd30,  1'b0, 1'b1, 4'd5},
    {1'b0, 1'b0, 7'd0,   1'b0, 1'b0, 4'd5},
    {1'b1, 1'b0, 7'd90,  1'b1, 1'b0, 4'd2},
    {1'b0, 1'b0, 7'd127, 1'b0, 1'b0, 4'd10}   // R10 top code ends travel
  };

  task automatic check(input string req, input logic eu, input logic ed);
    checks++;
    if (up !== eu || down !== ed) begin
      fails++;
      $display("FAIL %s: up/down=%b%b expected %b%b", req, up, down, eu, ed);
    end
    checks++;
    if (up === 1'b1 && down === 1'b1) begin  // R9
      fails++;
      $display("FAIL R9: up/down=%b%b expected not 11", up, down);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run incomplete, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; open_c = 1'b0; close_c = 1'b0; pos = 7'd10;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      {open_c, close_c, pos} = VEC[i][14:6];
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][3:0]), VEC[i][5], VEC[i][4]);
    end

    // R1: reset mid-travel drops drive without a clock edge
    open_c = 1'b1; close_c = 1'b0; pos = 7'd20;
    @(negedge clk);
    open_c = 1'b0;
    check("R2", 1'b1, 1'b0);
    #3 rst_n = 1'b0;
    #2 check("R1", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    // R10: open command at out-of-range reading stays stopped
    open_c = 1'b1; pos = 7'd101;
    @(negedge clk);
    check("R10", 1'b0, 1'b0);
    open_c = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule